// File: doc/BRIEF.md
# Three-Level DMA Descriptor Loader

This block sits in front of the transfer engine of one DMA channel. It fetches descriptors from a linked structure in memory that has three levels. A group descriptor points down to a context descriptor. A context descriptor remembers where its data-descriptor list stopped. A data descriptor names the buffer to move. Software never hands the engine a flat chain. It walks down the hierarchy with separate load commands, and each command fetches exactly one descriptor over a word-wide read port. The block latches the fields of that descriptor as outputs for the engine.

Software writes one of two start pointers and then issues commands through a command register. There are two ways to begin:
- **From a group:** write the group pointer, then issue load-group, load-context and load-data-with-burst.
- **From a context:** write the group-down pointer, then issue load-context and load-data-with-burst.

A busy flag covers each command from the cycle it is written until its last memory word has returned. The burst flag on a load-data command raises a one-cycle start pulse toward the transfer engine once the data descriptor is in place.

Top module: `ldr_top`

## Requirements
- R1: While reset is held, busy, the memory read request, the start pulse, the group-loaded flag and every latched field output are zero.
- R2: Writing a command (`sw_sel_i` = 2, code in `sw_wdata_i[3:0]`) while idle makes busy high from the next clock edge. Busy stays high until the edge that captures the last word of that descriptor, and falls on that edge.
- R3: A command write that arrives while busy is high is ignored. It causes no memory read and does not change the descriptor being fetched.
- R4: Command code 1 (load group) reads four words at the group pointer (`sw_sel_i` = 0) plus byte offsets 0, 4, 8 and 12, in that order. Word 0 is next, word 1 is control, word 2 is up and word 3 is down.
- R5: Command code 2 (load context) reads eight words in ascending order. The base is the latched group down field if a group has been loaded since the last group-down pointer write, and otherwise the group-down pointer register (`sw_sel_i` = 1). Word 1 is control, word 6 is the saved data-descriptor pointer and word 7 is the saved buffer pointer.
- R6: Command code 3 (load data) reads four words starting at the latched context's saved data pointer. The words are next, buffer, control and after, in that order.
- R7: Load data with bit 4 of the command word set gives a single-cycle `xfer_start_o` pulse, on the edge where busy falls. Load data without bit 4, and any other command even with bit 4 set, gives no pulse.
- R8: A command code other than 1, 2 or 3 issues no read. Busy is high for exactly one cycle.
- R9: A write to the group-down pointer clears the group-loaded flag. The next load context therefore uses the register value.
- R10: The read request, once raised, holds its address stable until `mem_rd_valid_i` completes the read. Only one read is outstanding at a time.
- R11: The group control word decodes to `grp_flags_o` = {bit 15 disable, bit 7 enable, bit 4 interrupt, bit 2 begin-of-list, bit 1 top-of-list, bit 0 end-of-list}, and `grp_md_o` = bits 31:16.
- R12: The context control word decodes to `ctx_flags_o` = {bit 15 disable, bit 7 enable, bit 6 store mode, bit 4 interrupt, bit 0 end-of-list}, and `ctx_md0_o` = bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_we_i | input | 1 | Software write strobe |
| sw_sel_i | input | 2 | Write target: 0 group pointer, 1 group-down pointer, 2 command |
| sw_wdata_i | input | 32 | Write data |
| busy_o | output | 1 | Command in progress |
| mem_rd_req_o | output | 1 | Memory read request, held until valid |
| mem_rd_addr_o | output | ADDR_W | Byte address of the requested word |
| mem_rd_valid_i | input | 1 | Read data valid, completes the request |
| mem_rd_data_i | input | 32 | Read data |
| grp_loaded_o | output | 1 | A group descriptor is latched and selects the context base |
| grp_next_o | output | ADDR_W | Group next pointer |
| grp_up_o | output | ADDR_W | Group up pointer |
| grp_down_o | output | ADDR_W | Group down pointer |
| grp_flags_o | output | 6 | Decoded group flags |
| grp_md_o | output | 16 | Group metadata |
| ctx_flags_o | output | 5 | Decoded context flags |
| ctx_md0_o | output | 16 | Context metadata field 0 |
| ctx_dat_ptr_o | output | ADDR_W | Saved data-descriptor pointer |
| ctx_buf_ptr_o | output | ADDR_W | Saved buffer pointer |
| dat_next_o | output | ADDR_W | Data descriptor next pointer |
| dat_buf_o | output | ADDR_W | Data descriptor buffer pointer |
| dat_ctrl_o | output | 32 | Data descriptor control word |
| dat_after_o | output | ADDR_W | Data descriptor end-of-buffer pointer |
| xfer_start_o | output | 1 | One-cycle start pulse to the transfer engine |

## Verification
The assertions check the following on every cycle:
- busy rises after an accepted command;
- a command written while busy leaves the fetch untouched;
- the read address is held while a request waits;
- an unknown code ends after one cycle;
- the start pulse is single and coincides with idle;
- a group-down write clears the group-loaded flag;
- a completed group load steers the context base to its down field.

Only the bench scenarios can show that the right addresses are read in the right order for each level. They also show that every latched field and decoded flag matches memory contents, that the start-from-group and start-from-context paths both reach the intended data descriptor, and that no extra read follows an ignored or unknown command.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;

  localparam int GRP_WORDS = 4;
  localparam int CTX_WORDS = 8;
  localparam int DAT_WORDS = 4;
  localparam int IDX_W     = $clog2(CTX_WORDS);

  localparam logic [1:0] SEL_GRP_PTR = 2'd0;
  localparam logic [1:0] SEL_DOWN_PTR = 2'd1;
  localparam logic [1:0] SEL_CMD     = 2'd2;

  localparam logic [3:0] OP_GRP = 4'd1;
  localparam logic [3:0] OP_CTX = 4'd2;
  localparam logic [3:0] OP_DAT = 4'd3;
  localparam int BURST_BIT = 4;

  localparam int GI_NEXT = 0, GI_CTRL = 1, GI_UP = 2, GI_DOWN = 3;
  localparam int CI_CTRL = 1, CI_DAT = 6, CI_BUF = 7;
  localparam int DI_NEXT = 0, DI_BUF = 1, DI_CTRL = 2, DI_AFTER = 3;

  typedef enum logic [1:0] {K_GRP, K_CTX, K_DAT} kind_e;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_DROP} state_e;

  function automatic logic [IDX_W-1:0] last_idx(kind_e k);
    case (k)
      K_GRP:   return IDX_W'(GRP_WORDS - 1);
      K_CTX:   return IDX_W'(CTX_WORDS - 1);
      default: return IDX_W'(DAT_WORDS - 1);
    endcase
  endfunction

  // {dis, en, intr, bol, tol, eol}
  function automatic logic [5:0] grp_flags_of(logic [WORD_W-1:0] w);
    return {w[15], w[7], w[4], w[2], w[1], w[0]};
  endfunction

  // {dis, en, store_mode, intr, eol}
  function automatic logic [4:0] ctx_flags_of(logic [WORD_W-1:0] w);
    return {w[15], w[7], w[6], w[4], w[0]};
  endfunction

endpackage

// File: rtl/ldr_swregs.sv
module ldr_swregs
  import ldr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [WORD_W-1:0] wdata,
  output logic [ADDR_W-1:0] grp_ptr,
  output logic [ADDR_W-1:0] down_ptr,
  output logic              down_we,
  output logic              cmd_we
);

  assign cmd_we  = we && (sel == SEL_CMD);
  assign down_we = we && (sel == SEL_DOWN_PTR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_ptr  <= '0;
      down_ptr <= '0;
    end else begin
      if (we && (sel == SEL_GRP_PTR)) grp_ptr <= wdata[ADDR_W-1:0];
      if (down_we)                    down_ptr <= wdata[ADDR_W-1:0];
    end
  end

endmodule

// File: rtl/ldr_seq.sv
module ldr_seq
  import ldr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [4:0]        cmd_word,
  input  logic [ADDR_W-1:0] grp_base,
  input  logic [ADDR_W-1:0] ctx_base,
  input  logic [ADDR_W-1:0] dat_base,
  input  logic              mem_valid,
  input  logic [WORD_W-1:0] mem_data,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              cap_en,
  output kind_e             cap_kind,
  output logic [IDX_W-1:0]  cap_idx,
  output logic [WORD_W-1:0] cap_data,
  output logic              load_done,
  output logic              xfer_start
);

  function automatic logic [ADDR_W-1:0] word_addr(logic [ADDR_W-1:0] b, logic [IDX_W-1:0] i);
    return b + ADDR_W'(i) * ADDR_W'(WORD_BYTES);
  endfunction

  state_e            st_q;
  kind_e             kind_q;
  logic              burst_q;
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  idx_q;
  logic              start_q;

  logic [3:0]        op;
  logic              op_known;
  kind_e             op_kind;
  logic [ADDR_W-1:0] op_base;
  logic              word_done;
  logic              last_word;

  assign op = cmd_word[3:0];

  always_comb begin
    op_known = 1'b1;
    op_kind  = K_GRP;
    op_base  = grp_base;
    case (op)
      OP_GRP: ;
      OP_CTX: begin op_kind = K_CTX; op_base = ctx_base; end
      OP_DAT: begin op_kind = K_DAT; op_base = dat_base; end
      default: op_known = 1'b0;
    endcase
  end

  assign word_done = (st_q == ST_READ) && mem_valid;
  assign last_word = (idx_q == last_idx(kind_q));
  assign load_done = word_done && last_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      kind_q  <= K_GRP;
      burst_q <= 1'b0;
      base_q  <= '0;
      idx_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= load_done && (kind_q == K_DAT) && burst_q;
      case (st_q)
        ST_IDLE: if (cmd_we) begin
          if (op_known) begin
            st_q    <= ST_READ;
            kind_q  <= op_kind;
            base_q  <= op_base;
            burst_q <= (op == OP_DAT) && cmd_word[BURST_BIT];
            idx_q   <= '0;
          end else begin
            st_q <= ST_DROP;
          end
        end
        ST_READ: if (word_done) begin
          if (last_word) st_q <= ST_IDLE;
          else           idx_q <= idx_q + 1'b1;
        end
        ST_DROP: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (st_q != ST_IDLE);
  assign mem_req    = (st_q == ST_READ);
  assign mem_addr   = word_addr(base_q, idx_q);
  assign cap_en     = word_done;
  assign cap_kind   = kind_q;
  assign cap_idx    = idx_q;
  assign cap_data   = mem_data;
  assign xfer_start = start_q;

  p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !busy) |=> busy);

  p_ignore_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && busy) |=> ($stable(kind_q) && $stable(base_q)));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  p_drop_short_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DROP) |=> !busy);

  p_start_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> !mem_req);

  p_start_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);

endmodule

// File: rtl/ldr_store.sv
module ldr_store
  import ldr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  kind_e             cap_kind,
  input  logic [IDX_W-1:0]  cap_idx,
  input  logic [WORD_W-1:0] cap_data,
  input  logic              load_done,
  input  logic              down_we,
  input  logic [ADDR_W-1:0] down_ptr,
  output logic              grp_loaded,
  output logic [ADDR_W-1:0] grp_next,
  output logic [ADDR_W-1:0] grp_up,
  output logic [ADDR_W-1:0] grp_down,
  output logic [5:0]        grp_flags,
  output logic [15:0]       grp_md,
  output logic [4:0]        ctx_flags,
  output logic [15:0]       ctx_md0,
  output logic [ADDR_W-1:0] ctx_dat,
  output logic [ADDR_W-1:0] ctx_buf,
  output logic [ADDR_W-1:0] dat_next,
  output logic [ADDR_W-1:0] dat_buf,
  output logic [WORD_W-1:0] dat_ctrl,
  output logic [ADDR_W-1:0] dat_after,
  output logic [ADDR_W-1:0] ctx_base,
  output logic [ADDR_W-1:0] dat_base
);

  logic [ADDR_W-1:0] ptr;
  logic              grp_done;

  assign ptr      = cap_data[ADDR_W-1:0];
  assign grp_done = load_done && (cap_kind == K_GRP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_loaded <= 1'b0;
      grp_next   <= '0;
      grp_up     <= '0;
      grp_down   <= '0;
      grp_flags  <= '0;
      grp_md     <= '0;
      ctx_flags  <= '0;
      ctx_md0    <= '0;
      ctx_dat    <= '0;
      ctx_buf    <= '0;
      dat_next   <= '0;
      dat_buf    <= '0;
      dat_ctrl   <= '0;
      dat_after  <= '0;
    end else begin
      if (down_we)       grp_loaded <= 1'b0;
      else if (grp_done) grp_loaded <= 1'b1;
      if (cap_en) begin
        case (cap_kind)
          K_GRP: case (int'(cap_idx))
            GI_NEXT: grp_next <= ptr;
            GI_CTRL: begin
              grp_flags <= grp_flags_of(cap_data);
              grp_md    <= cap_data[31:16];
            end
            GI_UP:   grp_up   <= ptr;
            GI_DOWN: grp_down <= ptr;
            default: ;
          endcase
          K_CTX: case (int'(cap_idx))
            CI_CTRL: begin
              ctx_flags <= ctx_flags_of(cap_data);
              ctx_md0   <= cap_data[31:16];
            end
            CI_DAT:  ctx_dat <= ptr;
            CI_BUF:  ctx_buf <= ptr;
            default: ;
          endcase
          default: case (int'(cap_idx))
            DI_NEXT:  dat_next  <= ptr;
            DI_BUF:   dat_buf   <= ptr;
            DI_CTRL:  dat_ctrl  <= cap_data;
            DI_AFTER: dat_after <= ptr;
            default: ;
          endcase
        endcase
      end
    end
  end

  assign ctx_base = grp_loaded ? grp_down : down_ptr;
  assign dat_base = ctx_dat;

  p_down_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    down_we |=> !grp_loaded);

  p_ctx_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_done && !down_we) |=> (grp_loaded && ctx_base == $past(ptr)));

endmodule

// File: rtl/ldr_top.sv
module ldr_top
  import ldr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we_i,
  input  logic [1:0]        sw_sel_i,
  input  logic [31:0]       sw_wdata_i,
  output logic              busy_o,
  output logic              mem_rd_req_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic              mem_rd_valid_i,
  input  logic [31:0]       mem_rd_data_i,
  output logic              grp_loaded_o,
  output logic [ADDR_W-1:0] grp_next_o,
  output logic [ADDR_W-1:0] grp_up_o,
  output logic [ADDR_W-1:0] grp_down_o,
  output logic [5:0]        grp_flags_o,
  output logic [15:0]       grp_md_o,
  output logic [4:0]        ctx_flags_o,
  output logic [15:0]       ctx_md0_o,
  output logic [ADDR_W-1:0] ctx_dat_ptr_o,
  output logic [ADDR_W-1:0] ctx_buf_ptr_o,
  output logic [ADDR_W-1:0] dat_next_o,
  output logic [ADDR_W-1:0] dat_buf_o,
  output logic [31:0]       dat_ctrl_o,
  output logic [ADDR_W-1:0] dat_after_o,
  output logic              xfer_start_o
);

  logic [ADDR_W-1:0] grp_ptr, down_ptr, ctx_base, dat_base;
  logic              down_we, cmd_we;
  logic              cap_en, load_done;
  kind_e             cap_kind;
  logic [IDX_W-1:0]  cap_idx;
  logic [WORD_W-1:0] cap_data;

  ldr_swregs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(sw_we_i), .sel(sw_sel_i), .wdata(sw_wdata_i),
    .grp_ptr(grp_ptr), .down_ptr(down_ptr), .down_we(down_we), .cmd_we(cmd_we)
  );

  ldr_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_word(sw_wdata_i[4:0]),
    .grp_base(grp_ptr), .ctx_base(ctx_base), .dat_base(dat_base),
    .mem_valid(mem_rd_valid_i), .mem_data(mem_rd_data_i),
    .busy(busy_o), .mem_req(mem_rd_req_o), .mem_addr(mem_rd_addr_o),
    .cap_en(cap_en), .cap_kind(cap_kind), .cap_idx(cap_idx), .cap_data(cap_data),
    .load_done(load_done), .xfer_start(xfer_start_o)
  );

  ldr_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_kind(cap_kind),
    .cap_idx(cap_idx), .cap_data(cap_data), .load_done(load_done),
    .down_we(down_we), .down_ptr(down_ptr),
    .grp_loaded(grp_loaded_o), .grp_next(grp_next_o), .grp_up(grp_up_o),
    .grp_down(grp_down_o), .grp_flags(grp_flags_o), .grp_md(grp_md_o),
    .ctx_flags(ctx_flags_o), .ctx_md0(ctx_md0_o), .ctx_dat(ctx_dat_ptr_o),
    .ctx_buf(ctx_buf_ptr_o), .dat_next(dat_next_o), .dat_buf(dat_buf_o),
    .dat_ctrl(dat_ctrl_o), .dat_after(dat_after_o),
    .ctx_base(ctx_base), .dat_base(dat_base)
  );

endmodule

// File: tb/test_ldr_top.sv
module test_ldr_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sw_we;
  logic [1:0]  sw_sel;
  logic [31:0] sw_wdata;
  logic        busy, req, valid, start, gl;
  logic [31:0] addr, rdata;
  logic [31:0] g_next, g_up, g_down, c_dat, c_buf, d_next, d_buf, d_ctrl, d_after;
  logic [5:0]  g_flags;
  logic [15:0] g_md, c_md0;
  logic [4:0]  c_flags;

  always #4 clk = ~clk;

  ldr_top i_ldr_top (
    .clk(clk), .rst_n(rst_n), .sw_we_i(sw_we), .sw_sel_i(sw_sel), .sw_wdata_i(sw_wdata),
    .busy_o(busy), .mem_rd_req_o(req), .mem_rd_addr_o(addr),
    .mem_rd_valid_i(valid), .mem_rd_data_i(rdata),
    .grp_loaded_o(gl), .grp_next_o(g_next), .grp_up_o(g_up), .grp_down_o(g_down),
    .grp_flags_o(g_flags), .grp_md_o(g_md), .ctx_flags_o(c_flags), .ctx_md0_o(c_md0),
    .ctx_dat_ptr_o(c_dat), .ctx_buf_ptr_o(c_buf), .dat_next_o(d_next),
    .dat_buf_o(d_buf), .dat_ctrl_o(d_ctrl), .dat_after_o(d_after),
    .xfer_start_o(start)
  );

  int checks = 0;
  int fails = 0;
  int rd_seen = 0;
  int starts = 0;
  bit done = 0;
  logic [31:0] mem [0:127];
  logic [31:0] exp_q [$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_reads(logic [31:0] base, int n);
    for (int i = 0; i < n; i++) exp_q.push_back(base + 32'(4 * i));
  endtask

  task automatic sw_write(logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_sel = s; sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic wait_idle(string tag);
    int n = 0;
    while (busy && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " all reads returned"}, 32'(exp_q.size()), 32'd0);
  endtask

  // memory responder and read monitor (scoreboard)
  initial begin : responder
    int cnt;
    logic [31:0] held, e;
    cnt = 0; held = '0; e = '0;
    valid = 1'b0; rdata = '0;
    forever begin
      @(negedge clk);
      if (valid) begin
        valid = 1'b0;
        cnt = 0;
      end else if (rst_n && req) begin
        if (cnt == 0) held = addr;
        else chk("R10 address held while waiting", addr, held);
        cnt++;
        if (cnt >= 1 + (rd_seen % 3)) begin
          valid = 1'b1;
          rdata = mem[addr[8:2]];
          rd_seen++;
          if (exp_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R3 unexpected read actual=%h expected=none", addr);
          end else begin
            e = exp_q.pop_front();
            chk("R4 R5 R6 read address order", addr, e);
          end
        end
      end
    end
  end

  initial begin : start_mon
    forever begin
      @(negedge clk);
      if (rst_n && start) begin
        starts++;
        chk("R7 start coincides with busy low", {31'd0, busy}, 32'd0);
      end
    end
  end

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int rd0, st0;
    for (int i = 0; i < 128; i++) mem[i] = 32'h0;
    mem[16] = 32'h1111_0000; mem[17] = 32'hBEEF_0095; mem[18] = 32'h2222_0000; mem[19] = 32'h0000_0080;
    mem[32] = 32'h3333_0000; mem[33] = 32'h1234_8050;
    for (int i = 34; i < 38; i++) mem[i] = 32'hA0 + 32'(i);
    mem[38] = 32'h0000_00C0; mem[39] = 32'hDEAD_0000;
    mem[48] = 32'h4444_0000; mem[49] = 32'hB0F0_0000; mem[50] = 32'h0000_0801; mem[51] = 32'hAF7E_0000;
    mem[64] = 32'h5555_0000; mem[65] = 32'h5678_0081; mem[70] = 32'h0000_0140; mem[71] = 32'hCAFE_0000;
    mem[80] = 32'h6666_0000; mem[81] = 32'h0B0B_0000; mem[82] = 32'h0000_0009; mem[83] = 32'h7777_0000;

    rst_n = 1'b0; sw_we = 1'b0; sw_sel = 2'd0; sw_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 read request", {31'd0, req}, 32'd0);
    chk("R1 start", {31'd0, start}, 32'd0);
    chk("R1 group loaded", {31'd0, gl}, 32'd0);
    chk("R1 group down", g_down, 32'd0);
    chk("R1 data buffer", d_buf, 32'd0);
    rst_n = 1'b1;

    // start from a group
    sw_write(2'd0, 32'h40);
    push_reads(32'h40, 4);
    sw_write(2'd2, 32'h1);
    chk("R2 busy after command", {31'd0, busy}, 32'd1);
    rd0 = rd_seen;
    sw_write(2'd2, 32'h3);   // arrives while busy: ignored
    wait_idle("R2");
    chk("R3 ignored command made no reads", 32'(rd_seen - rd0), 32'd3);
    chk("R4 group next", g_next, 32'h1111_0000);
    chk("R4 group up", g_up, 32'h2222_0000);
    chk("R4 group down", g_down, 32'h80);
    chk("R11 group flags", {26'd0, g_flags}, 32'b011101);
    chk("R11 group metadata", {16'd0, g_md}, 32'hBEEF);
    chk("R9 group loaded set", {31'd0, gl}, 32'd1);

    push_reads(32'h80, 8);
    sw_write(2'd2, 32'h2);
    wait_idle("R5");
    chk("R5 saved data pointer", c_dat, 32'hC0);
    chk("R5 saved buffer pointer", c_buf, 32'hDEAD_0000);
    chk("R12 context flags", {27'd0, c_flags}, 32'b10110);
    chk("R12 context md0", {16'd0, c_md0}, 32'h1234);

    st0 = starts;
    push_reads(32'hC0, 4);
    sw_write(2'd2, 32'h13);
    wait_idle("R6");
    @(negedge clk);
    chk("R7 one pulse for burst load", 32'(starts - st0), 32'd1);
    chk("R6 data next", d_next, 32'h4444_0000);
    chk("R6 data buffer", d_buf, 32'hB0F0_0000);
    chk("R6 data control", d_ctrl, 32'h0801);
    chk("R6 data after", d_after, 32'hAF7E_0000);

    st0 = starts;
    push_reads(32'hC0, 4);
    sw_write(2'd2, 32'h3);
    wait_idle("R7");
    push_reads(32'h40, 4);
    sw_write(2'd2, 32'h11);
    wait_idle("R7");
    repeat (2) @(negedge clk);
    chk("R7 no pulse without burst or on group", 32'(starts - st0), 32'd0);

    // unknown code
    rd0 = rd_seen;
    sw_write(2'd2, 32'h7);
    chk("R8 busy during unknown code", {31'd0, busy}, 32'd1);
    @(negedge clk);
    chk("R8 busy cleared after one cycle", {31'd0, busy}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R8 no read for unknown code", 32'(rd_seen - rd0), 32'd0);

    // start from a context
    sw_write(2'd1, 32'h100);
    chk("R9 group loaded cleared", {31'd0, gl}, 32'd0);
    push_reads(32'h100, 8);
    sw_write(2'd2, 32'h2);
    wait_idle("R9");
    chk("R9 context from register", c_dat, 32'h140);
    chk("R12 second context flags", {27'd0, c_flags}, 32'b01001);
    st0 = starts;
    push_reads(32'h140, 4);
    sw_write(2'd2, 32'h13);
    wait_idle("R6");
    @(negedge clk);
    chk("R6 second data buffer", d_buf, 32'h0B0B_0000);
    chk("R7 burst pulse from context path", 32'(starts - st0), 32'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule